// File: doc/BRIEF.md
# Serial Management Register Slave (Indirect Addressing)

This block is a managed device on a two-wire management bus: a clock line driven by a station master, and a bidirectional data line. The block samples the data line on rising clock edges and decodes each frame as it arrives. A frame has a run of ones, a start code, an operation code, a port number and a device number, then a turnaround and a 16-bit payload. The device holds a 16-bit current-address pointer into a small bank of 16-bit registers. An address frame loads the pointer and a write frame stores the payload at the pointer. Two kinds of read frame return the word at the pointer, and one of them also advances the pointer afterwards. A master can therefore scan a block of registers with one address frame followed by repeated read-and-advance frames.

The bus clock and data are brought into the system clock domain through a synchronizer. The block samples after a detected rising edge of the bus clock and updates its output and output enable only after a detected falling edge. The line is thus stable while the master samples. A separate word-wide port lets local logic read and write the same register bank.

Top module: `mgmt_serial_slave`

## Requirements
- R1: After reset the output enable is low, every register holds 0x0000 and the current address is 0x0000.
- R2: A frame is accepted only if at least 32 consecutive ones precede the start code. A zero inside the run restarts the count. A frame with fewer ones causes no write, no address change and no driving of the line.
- R3: After the start code 0b00, the fields are taken MSB first in this order: a 2-bit operation, a 5-bit port number and a 5-bit device number. If either number differs from the configured value, the frame is ignored and the line is never driven.
- R4: Operation 0b00 loads the current address with the 16-bit payload, sent MSB first after a 2-bit turnaround that the master drives.
- R5: Operation 0b01 stores the 16-bit payload at the current address and leaves the address unchanged.
- R6: Operation 0b11 returns the word at the current address, MSB first, and leaves the address unchanged.
- R7: Operation 0b10 returns the word at the current address and then adds one to the address. The address wraps from 0xFFFF to 0x0000.
- R8: On a read, the line is released during the first turnaround bit and driven to 0 during the second. It carries the 16 data bits after that and is released from the bit time after the last data bit.
- R9: Addresses at or above the bank depth read as 0x0000, and writes to them change no register.
- R10: The local port reads any register combinationally and writes it on a clock with its write enable. A bus write to the same register in the same cycle takes priority.
- R11: The output enable and output value change only after a falling edge of the bus clock. They hold steady while the bus clock is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mdc | input | 1 | Management bus clock from the master |
| mdioIn | input | 1 | Resolved level of the data line |
| mdioOut | output | 1 | Value driven onto the data line |
| mdioOe | output | 1 | Drive enable for the data line (high = drive) |
| portAddr | input | 5 | Configured port number to match |
| devAddr | input | 5 | Configured device number to match |
| userWe | input | 1 | Local write enable |
| userAddr | input | log2(NUM_REGS) | Local register index |
| userWdata | input | 16 | Local write data |
| userRdata | output | 16 | Local read data |

## Verification
Directed frames test each operation on its own. Back-to-back reads with and without increment separate the address-holding read from the advancing one, and an advance from 0xFFFF exposes the wrap and the zero return of unimplemented locations. Runs of 31 ones and a run broken by a zero separate a correct count from a counter that saturates or never restarts. Frames with a wrong port or device number confirm that matching uses both fields. A seeded random mix of all four operations over in-range, out-of-range and top-of-space addresses is checked against a model of the bank and pointer, and each read also checks the turnaround shape and the release afterwards.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;

  localparam logic [1:0] OP_ADDR  = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_INCR  = 2'b10;
  localparam logic [1:0] OP_READ  = 2'b11;

  localparam int PRT_W = 5;
  localparam int DEV_W = 5;
  localparam int HDR_W = 2 + PRT_W + DEV_W;

  typedef enum logic [2:0] {
    PH_PRE, PH_START, PH_HDR, PH_TA1, PH_TA2, PH_RDAT, PH_WTA, PH_WDAT
  } phase_t;

  typedef struct packed {
    logic sampBit;
    logic loadRd;
    logic incAddr;
    logic shiftWr;
    logic commitAddr;
    logic commitWr;
    logic outEn;
    logic outData;
    logic outOff;
  } strobe_t;

endpackage

// File: rtl/mgmt_ctrl.sv
module mgmt_ctrl
  import mgmt_pkg::*;
#(
  parameter int PRE_LEN     = 32,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mdc,
  input  logic                mdioIn,
  input  logic [PRT_W-1:0]    portAddr,
  input  logic [DEV_W-1:0]    devAddr,
  output strobe_t             strb
);

  localparam int PCNT_W = $clog2(PRE_LEN + 1);
  localparam int BCNT_W = $clog2(DATA_W);
  localparam logic [BCNT_W-1:0] LAST_DATA = BCNT_W'(DATA_W - 1);
  localparam logic [BCNT_W-1:0] LAST_HDR  = BCNT_W'(HDR_W - 1);

  logic [SYNC_STAGES:0]   mdcSync;
  logic [SYNC_STAGES-1:0] dataSync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdcSync  <= '0;
      dataSync <= '1;
    end else begin
      mdcSync  <= {mdcSync[SYNC_STAGES-1:0], mdc};
      dataSync <= {dataSync[SYNC_STAGES-2:0], mdioIn};
    end
  end

  logic riseStb, fallStb, inBit;
  assign riseStb = mdcSync[SYNC_STAGES-1] & ~mdcSync[SYNC_STAGES];
  assign fallStb = ~mdcSync[SYNC_STAGES-1] & mdcSync[SYNC_STAGES];
  assign inBit   = dataSync[SYNC_STAGES-1];

  phase_t              phase;
  logic [PCNT_W-1:0]   preCnt;
  logic [BCNT_W-1:0]   bitCnt;
  logic [HDR_W-2:0]    hdr;
  logic [1:0]          opReg;

  logic [HDR_W-1:0]    fullHdr;
  logic [1:0]          hdrOp;
  logic                idMatch, hdrDone;

  assign fullHdr = {hdr, inBit};
  assign hdrOp   = fullHdr[HDR_W-1 -: 2];
  assign idMatch = (fullHdr[PRT_W+DEV_W-1 -: PRT_W] == portAddr) &&
                   (fullHdr[DEV_W-1:0] == devAddr);
  assign hdrDone = (phase == PH_HDR) && (bitCnt == LAST_HDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_PRE;
      preCnt <= '0;
      bitCnt <= '0;
      hdr    <= '0;
      opReg  <= OP_ADDR;
    end else if (riseStb) begin
      unique case (phase)
        PH_PRE: begin
          if (inBit) begin
            if (preCnt != PCNT_W'(PRE_LEN)) preCnt <= preCnt + 1'b1;
          end else begin
            preCnt <= '0;
            if (preCnt == PCNT_W'(PRE_LEN)) phase <= PH_START;
          end
        end
        PH_START: begin
          bitCnt <= '0;
          phase  <= inBit ? PH_PRE : PH_HDR;
        end
        PH_HDR: begin
          hdr <= fullHdr[HDR_W-2:0];
          if (hdrDone) begin
            bitCnt <= '0;
            opReg  <= hdrOp;
            if (!idMatch)      phase <= PH_PRE;
            else if (hdrOp[1]) phase <= PH_TA1;
            else               phase <= PH_WTA;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        PH_TA1: phase <= PH_TA2;
        PH_TA2: begin
          bitCnt <= '0;
          phase  <= PH_RDAT;
        end
        PH_WTA: begin
          if (bitCnt == BCNT_W'(1)) begin
            bitCnt <= '0;
            phase  <= PH_WDAT;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        PH_RDAT, PH_WDAT: begin
          if (bitCnt == LAST_DATA) phase <= PH_PRE;
          else                     bitCnt <= bitCnt + 1'b1;
        end
        default: phase <= PH_PRE;
      endcase
    end
  end

  logic driving;
  assign driving = (phase == PH_TA2) || (phase == PH_RDAT);

  always_comb begin
    strb            = '0;
    strb.sampBit    = inBit;
    strb.loadRd     = riseStb && hdrDone && idMatch && hdrOp[1];
    strb.incAddr    = riseStb && hdrDone && idMatch && (hdrOp == OP_INCR);
    strb.shiftWr    = riseStb && (phase == PH_WDAT);
    strb.commitAddr = strb.shiftWr && (bitCnt == LAST_DATA) && (opReg == OP_ADDR);
    strb.commitWr   = strb.shiftWr && (bitCnt == LAST_DATA) && (opReg == OP_WRITE);
    strb.outEn      = fallStb && driving;
    strb.outData    = fallStb && (phase == PH_RDAT);
    strb.outOff     = fallStb && !driving;
  end

  // R2: the start code is reached only after a full run of ones
  p_preamble_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_START && $past(phase) == PH_PRE) |-> $past(preCnt) == PCNT_W'(PRE_LEN));

  // R8: read data phase is entered only through the driven turnaround bit
  p_read_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RDAT && $past(phase) != PH_RDAT) |-> $past(phase) == PH_TA2);

  // R3: data phases follow a header only when the identifiers matched
  p_match_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_TA1 || phase == PH_WTA) && $past(phase) == PH_HDR |-> $past(idMatch));

endmodule

// File: rtl/mgmt_dpath.sv
module mgmt_dpath
  import mgmt_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 16,
  parameter int NUM_REGS = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  strobe_t                     strb,
  input  logic                        userWe,
  input  logic [$clog2(NUM_REGS)-1:0] userAddr,
  input  logic [DATA_W-1:0]           userWdata,
  output logic [DATA_W-1:0]           userRdata,
  output logic                        mdioOut,
  output logic                        mdioOe
);

  localparam int IDX_W = $clog2(NUM_REGS);

  logic [DATA_W-1:0] bank [NUM_REGS];
  logic [ADDR_W-1:0] curAddr;
  logic [DATA_W-1:0] rdShift;
  logic [DATA_W-1:0] wrShift;
  logic [DATA_W-1:0] wrWord;
  logic [DATA_W-1:0] curWord;
  logic              curHit;

  assign wrWord  = {wrShift[DATA_W-2:0], strb.sampBit};
  assign curHit  = (curAddr < ADDR_W'(NUM_REGS));
  assign curWord = curHit ? bank[curAddr[IDX_W-1:0]] : '0;
  assign userRdata = bank[userAddr];

  generate
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          bank[i] <= '0;
        else if (strb.commitWr && curAddr == ADDR_W'(i))
          bank[i] <= wrWord;
        else if (userWe && userAddr == IDX_W'(i))
          bank[i] <= userWdata;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      curAddr <= '0;
      wrShift <= '0;
      rdShift <= '0;
    end else begin
      if (strb.shiftWr)    wrShift <= wrWord;
      if (strb.commitAddr) curAddr <= wrWord;
      else if (strb.incAddr) curAddr <= curAddr + 1'b1;
      if (strb.loadRd)       rdShift <= curWord;
      else if (strb.outData) rdShift <= {rdShift[DATA_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdioOe  <= 1'b0;
      mdioOut <= 1'b0;
    end else if (strb.outOff) begin
      mdioOe  <= 1'b0;
      mdioOut <= 1'b0;
    end else if (strb.outEn) begin
      mdioOe  <= 1'b1;
      mdioOut <= strb.outData ? rdShift[DATA_W-1] : 1'b0;
    end
  end

  // R11: line state moves only right after a detected falling bus edge
  p_out_on_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({mdioOe, mdioOut}) |-> $past(strb.outEn || strb.outOff));

  // R8: the first driven bit of a read is the zero turnaround bit
  p_ta_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdioOe) |-> !mdioOut);

  // R7: advancing read adds exactly one, wrapping at the top
  p_incr_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    strb.incAddr |=> curAddr == ADDR_W'($past(curAddr) + 1'b1));

  // R6: pointer holds unless an address frame or an advancing read acts
  p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(strb.incAddr || strb.commitAddr) |=> $stable(curAddr));

endmodule

// File: rtl/mgmt_serial_slave.sv
module mgmt_serial_slave
  import mgmt_pkg::*;
#(
  parameter int PRE_LEN     = 32,
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 16,
  parameter int NUM_REGS    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        mdc,
  input  logic                        mdioIn,
  output logic                        mdioOut,
  output logic                        mdioOe,
  input  logic [4:0]                  portAddr,
  input  logic [4:0]                  devAddr,
  input  logic                        userWe,
  input  logic [$clog2(NUM_REGS)-1:0] userAddr,
  input  logic [DATA_W-1:0]           userWdata,
  output logic [DATA_W-1:0]           userRdata
);

  strobe_t strb;

  mgmt_ctrl #(
    .PRE_LEN(PRE_LEN), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdioIn(mdioIn),
    .portAddr(portAddr), .devAddr(devAddr), .strb(strb)
  );

  mgmt_dpath #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)
  ) u_dpath (
    .clk(clk), .rst_n(rst_n), .strb(strb),
    .userWe(userWe), .userAddr(userAddr), .userWdata(userWdata),
    .userRdata(userRdata), .mdioOut(mdioOut), .mdioOe(mdioOe)
  );

endmodule

// File: tb/tb_mgmt_serial_slave.sv
module tb_mgmt_serial_slave;

  localparam int NREG = 16;
  localparam logic [4:0] MY_PRT = 5'h13;
  localparam logic [4:0] MY_DEV = 5'h05;

  logic clk = 0;
  logic rst_n = 0;
  logic mdc = 0;
  logic masterOe = 0, masterBit = 1;
  logic mdioOut, mdioOe, mdioLine;
  logic userWe = 0;
  logic [3:0] userAddr = 0;
  logic [15:0] userWdata = 0, userRdata;

  int checks = 0, errors = 0;
  logic stableOk = 1;

  logic [15:0] expReg [NREG];
  logic [15:0] expAddr;

  always #2 clk = ~clk;

  assign mdioLine = mdioOe ? mdioOut : (masterOe ? masterBit : 1'b1);

  mgmt_serial_slave dut (
    .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdioIn(mdioLine),
    .mdioOut(mdioOut), .mdioOe(mdioOe),
    .portAddr(MY_PRT), .devAddr(MY_DEV),
    .userWe(userWe), .userAddr(userAddr), .userWdata(userWdata),
    .userRdata(userRdata)
  );

  function automatic logic [15:0] modelRead(input logic [15:0] a);
    return (a < 16'(NREG)) ? expReg[a[3:0]] : 16'h0000;
  endfunction

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // one bus bit: low half then high half; sample before the rising edge
  task automatic bitT(input logic drv, input logic b, output logic o, output logic v);
    logic oMid, vMid;
    @(negedge clk); mdc = 0; masterOe = drv; masterBit = b;
    repeat (7) @(negedge clk);
    o = mdioOe; v = mdioLine;
    @(negedge clk); mdc = 1;
    repeat (3) @(negedge clk);
    oMid = mdioOe; vMid = mdioOut;
    repeat (4) @(negedge clk);
    if (mdioOe !== oMid || (oMid && mdioOut !== vMid)) stableOk = 0;
  endtask

  task automatic frame(input logic [1:0] op, input logic [4:0] prt, input logic [4:0] dev,
                       input logic [15:0] wd, input int preLen, input int breakAt,
                       output logic [15:0] rd, output logic drove, output logic taOk,
                       output logic relOk);
    logic o, v;
    logic [11:0] hdr;
    drove = 0; rd = 0; taOk = 1;
    hdr = {op, prt, dev};
    bitT(1, 0, o, v); drove |= o;
    for (int i = 0; i < preLen; i++) begin
      if (breakAt > 0 && i == breakAt) begin bitT(1, 0, o, v); drove |= o; end
      bitT(1, 1, o, v); drove |= o;
    end
    bitT(1, 0, o, v); drove |= o;
    bitT(1, 0, o, v); drove |= o;
    for (int i = 11; i >= 0; i--) begin bitT(1, hdr[i], o, v); drove |= o; end
    if (op[1]) begin
      bitT(0, 0, o, v); if (o) taOk = 0;
      bitT(0, 0, o, v); drove |= o; if (!o || v) taOk = 0;
      for (int i = 0; i < 16; i++) begin bitT(0, 0, o, v); drove |= o; rd = {rd[14:0], v}; end
    end else begin
      bitT(1, 1, o, v); drove |= o;
      bitT(1, 0, o, v); drove |= o;
      for (int i = 15; i >= 0; i--) begin bitT(1, wd[i], o, v); drove |= o; end
    end
    bitT(0, 0, o, v); relOk = !o;
    masterOe = 0;
  endtask

  task automatic busAddr(input logic [15:0] a, input string req);
    logic [15:0] rd; logic dr, ta, rl;
    frame(2'b00, MY_PRT, MY_DEV, a, 32, 0, rd, dr, ta, rl);
    expAddr = a;
    check({req, " addr frame no drive"}, 16'(dr), 16'h0);
  endtask

  task automatic busWrite(input logic [15:0] d, input string req);
    logic [15:0] rd; logic dr, ta, rl;
    frame(2'b01, MY_PRT, MY_DEV, d, 32, 0, rd, dr, ta, rl);
    if (expAddr < 16'(NREG)) expReg[expAddr[3:0]] = d;
    check({req, " write frame no drive"}, 16'(dr), 16'h0);
  endtask

  task automatic busRead(input logic inc, input string req);
    logic [15:0] rd; logic dr, ta, rl;
    frame(inc ? 2'b10 : 2'b11, MY_PRT, MY_DEV, 16'h0, 32, 0, rd, dr, ta, rl);
    check({req, " read data"}, rd, modelRead(expAddr));
    check("R8 turnaround+release", {14'h0, ta, rl}, 16'h3);
    if (inc) expAddr = expAddr + 16'h1;
  endtask

  task automatic userChk(input logic [3:0] a, input string req);
    @(negedge clk); userAddr = a; #1;
    check(req, userRdata, expReg[a]);
  endtask

  task automatic userWr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); userWe = 1; userAddr = a; userWdata = d;
    @(negedge clk); userWe = 0;
    expReg[a] = d;
  endtask

  task automatic mainSeq;
    logic [15:0] rd; logic dr, ta, rl;
    for (int i = 0; i < NREG; i++) expReg[i] = 16'h0;
    expAddr = 16'h0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R1 oe after reset", 16'(mdioOe), 16'h0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    userChk(4'd7, "R1 register cleared");
    busRead(0, "R1 reset pointer");

    busAddr(16'h0003, "R4");
    busWrite(16'hA5C3, "R5");
    userChk(4'd3, "R5 bus write visible");
    busRead(0, "R6 first");
    busRead(0, "R6 pointer unchanged");

    userWr(4'd4, 16'h1234);
    userWr(4'd5, 16'hBEEF);
    userChk(4'd5, "R10 local write");
    busAddr(16'h0004, "R4");
    busRead(1, "R7 advance first");
    busRead(1, "R7 advance second");
    busRead(0, "R7 pointer advanced to 6");

    busAddr(16'hFFFF, "R4");
    busRead(1, "R9 top of space reads zero");
    busRead(0, "R7 wrapped to zero");

    busAddr(16'h0100, "R9");
    busWrite(16'h5555, "R9");
    busRead(0, "R9 unimplemented reads zero");
    for (int i = 0; i < NREG; i++) userChk(4'(i), "R9 bank untouched");

    // short run of ones: write must be ignored
    busAddr(16'h0002, "R4");
    frame(2'b01, MY_PRT, MY_DEV, 16'h7777, 31, 0, rd, dr, ta, rl);
    userChk(4'd2, "R2 short preamble write ignored");
    frame(2'b11, MY_PRT, MY_DEV, 16'h0, 31, 0, rd, dr, ta, rl);
    check("R2 short preamble read no drive", 16'(dr), 16'h0);
    frame(2'b01, MY_PRT, MY_DEV, 16'h6666, 40, 20, rd, dr, ta, rl);
    userChk(4'd2, "R2 broken preamble write ignored");
    frame(2'b01, MY_PRT, MY_DEV, 16'h4444, 33, 0, rd, dr, ta, rl);
    expReg[2] = 16'h4444;
    userChk(4'd2, "R2 long preamble accepted");

    // identifier mismatch
    frame(2'b01, MY_PRT ^ 5'h10, MY_DEV, 16'h9999, 32, 0, rd, dr, ta, rl);
    userChk(4'd2, "R3 port mismatch write ignored");
    frame(2'b01, MY_PRT, MY_DEV ^ 5'h01, 16'h9999, 32, 0, rd, dr, ta, rl);
    userChk(4'd2, "R3 device mismatch write ignored");
    frame(2'b11, MY_PRT, MY_DEV ^ 5'h04, 16'h0, 32, 0, rd, dr, ta, rl);
    check("R3 mismatch read no drive", 16'(dr), 16'h0);
    frame(2'b00, MY_PRT ^ 5'h01, MY_DEV, 16'h000B, 32, 0, rd, dr, ta, rl);
    busRead(0, "R3 mismatch address ignored");

    // seeded random mix
    for (int it = 0; it < 28; it++) begin
      int op;
      op = $urandom % 4;
      case (op)
        0: begin
          logic [15:0] a;
          a = (($urandom % 5) == 0) ? 16'hFFFF : 16'($urandom % (NREG + 4));
          busAddr(a, "R4 random");
        end
        1: busWrite(16'($urandom), "R5 random");
        2: busRead(1, "R7 random");
        default: busRead(0, "R6 random");
      endcase
    end
    for (int i = 0; i < NREG; i++) userChk(4'(i), "R5 random bank contents");
    check("R11 output stable while bus clock high", 16'(stableOk), 16'h1);
  endtask

  initial begin
    fork
      mainSeq();
      begin
        repeat (190000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule